// File: doc/BRIEF.md
# Shared Interrupt Source Selector

This block decides, for each of four shared interrupt vectors, whether the request on that vector comes from its peripheral or from a timer compare/capture channel. By default the vectors belong, in order, to four peripheral sources: SPI receive/overrun, I2C, multiply-accumulate overflow and ADC/port-change. A vector passes to compare/capture channel n when that channel's 2-bit mode field selects compare mode. The peripheral request on that vector is then blocked, even if it is enabled. Each channel takes over only its own vector.

Two 8-bit registers control the routing, and both are written over a simple register bus. The enable register masks each vector and also holds a self-clearing watchdog start/refresh strobe. The mode register holds four 2-bit channel fields.

Each vector has a two-state ownership machine, decoded from its mode field:
- `OWN_PERIPH` is the reset state.
- The transition to `OWN_COMPARE` happens when a mode write sets the field to binary 10.
- The transition back to `OWN_PERIPH` happens when a mode write sets any other value.

The gated request is registered. Each request output is paired with a constant vector address.

Top module: `irq_share_sel`

## Requirements
- R1: A synchronous reset clears both registers, drives every `irq_req` bit low and drives `wdt_kick` low. Every vector then starts in `OWN_PERIPH`.
- R2: The address field `irq_vec_addr[16n+15:16n]` is 0x0053, 0x005B, 0x0063 and 0x006B for n = 0, 1, 2, 3.
- R3: A write with `wr_sel`=0 targets the enable register and a write with `wr_sel`=1 targets the mode register. `rd_data` shows the register picked by `rd_sel` with no delay. Enable bits 0 and 6 always read as 0.
- R4: Enable bits 2, 3, 4 and 5 gate vectors 0, 1, 2 and 3. A 1 allows the request and a 0 masks it.
- R5: When mode bits [2n+1:2n] equal binary 10, `cmp_evt[n]` drives vector n and `periph_req[n]` has no effect on it.
- R6: The mode field values 00, 01 and 11 leave vector n driven by `periph_req[n]`, and `cmp_evt[n]` has no effect on it.
- R7: Taking over one vector leaves the routing of the other three vectors unchanged.
- R8: A vector taken over by a compare channel is still masked by that vector's enable bit.
- R9: A write to the enable register with bit 6 set raises `wdt_kick` for exactly one cycle, in the cycle after the write edge.
- R10: `irq_req` reflects the inputs and registers sampled at the previous clock edge. A register write therefore changes `irq_req` one edge after the write edge.
- R11: Enable bits 7 and 1 are stored and read back, and they have no effect on `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects enable, 1 selects mode |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 selects enable, 1 selects mode |
| rd_data | output | 8 | Read data |
| periph_req | input | 4 | Raw peripheral requests, one per vector |
| cmp_evt | input | 4 | Compare events, one per channel |
| irq_req | output | 4 | Gated, registered vector requests |
| irq_vec_addr | output | 64 | Four 16-bit vector addresses |
| wdt_kick | output | 1 | One-cycle watchdog start/refresh pulse |

## Verification
A wrong ownership state shows at the ports one edge after the inputs change. The affected vector then follows the wrong source, so the source that should win and the source that should be blocked are driven to opposite levels. A stuck or misrouted enable bit shows up the same way, as a request that passes while masked or stays masked while enabled, and it also appears at once on `rd_data`. A strobe that fails to clear appears as a second `wdt_kick` cycle or as a 1 read back in bit 6.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
    localparam int NUM_VEC  = 4;
    localparam int REG_W    = 8;
    localparam int FIELD_W  = 2;
    localparam int ADDR_W   = 16;
    localparam int EN_BASE  = 2;
    localparam int WDT_BIT  = 6;
    localparam int RSV_BIT  = 0;
    localparam logic [FIELD_W-1:0] MODE_COMPARE = 2'b10;

    typedef enum logic {
        OWN_PERIPH  = 1'b0,
        OWN_COMPARE = 1'b1
    } owner_e;
endpackage

// File: rtl/isel_regs.sv
module isel_regs
    import irq_share_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         wr_sel,
    input  logic [REG_W-1:0]             wr_data,
    input  logic                         rd_sel,
    output logic [REG_W-1:0]             rd_data,
    output logic [NUM_VEC-1:0]           en_gate,
    output logic [FIELD_W*NUM_VEC-1:0]   mode_q,
    output logic                         wdt_kick
);
    localparam logic [REG_W-1:0] EN_KEEP =
        ~((REG_W'(1) << WDT_BIT) | (REG_W'(1) << RSV_BIT));

    logic [REG_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            mode_q   <= '0;
            wdt_kick <= 1'b0;
        end else begin
            wdt_kick <= wr_en && !wr_sel && wr_data[WDT_BIT];
            if (wr_en) begin
                if (!wr_sel) en_q   <= wr_data & EN_KEEP;
                else         mode_q <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = rd_sel ? mode_q : en_q;
        en_gate = en_q[EN_BASE +: NUM_VEC];
    end

    // R9: no strobe without a write on the previous edge
    assert_wdt_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wdt_kick);

    // R1: the strobe is low after reset
    assert_wdt_reset_R1: assert property (@(posedge clk)
        rst |=> !wdt_kick);
endmodule

// File: rtl/isel_route.sv
module isel_route
    import irq_share_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0053
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [FIELD_W-1:0] mode,
    input  logic               periph,
    input  logic               cmp,
    output logic               irq,
    output logic [ADDR_W-1:0]  addr
);
    owner_e owner;
    logic   src;

    always_comb begin
        unique case (mode)
            MODE_COMPARE: owner = OWN_COMPARE;
            default:      owner = OWN_PERIPH;
        endcase
    end

    always_comb begin
        unique case (owner)
            OWN_COMPARE: src = cmp;
            OWN_PERIPH:  src = periph;
            default:     src = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= en & src;
    end

    assign addr = VEC_ADDR;

    // R5: a compare-owned vector ignores its peripheral request
    assert_periph_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_COMPARE && !cmp) |=> !irq);

    // R6: a peripheral-owned vector ignores its compare event
    assert_cmp_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_PERIPH && !periph) |=> !irq);

    // R4 and R8: a cleared enable masks the vector in both states
    assert_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);

    // R1: every request is low after reset
    assert_irq_reset_R1: assert property (@(posedge clk)
        rst |=> !irq);
endmodule

// File: rtl/irq_share_sel.sv
module irq_share_sel
    import irq_share_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0053,
    parameter int                VEC_STEP = 8
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       wr_sel,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       rd_sel,
    output logic [REG_W-1:0]           rd_data,
    input  logic [NUM_VEC-1:0]         periph_req,
    input  logic [NUM_VEC-1:0]         cmp_evt,
    output logic [NUM_VEC-1:0]         irq_req,
    output logic [ADDR_W*NUM_VEC-1:0]  irq_vec_addr,
    output logic                       wdt_kick
);
    logic [NUM_VEC-1:0]         en_gate;
    logic [FIELD_W*NUM_VEC-1:0] mode_q;

    isel_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .en_gate  (en_gate),
        .mode_q   (mode_q),
        .wdt_kick (wdt_kick)
    );

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        isel_route #(
            .VEC_ADDR(ADDR_W'(VEC_BASE + ADDR_W'(g * VEC_STEP)))
        ) u_route (
            .clk    (clk),
            .rst    (rst),
            .en     (en_gate[g]),
            .mode   (mode_q[g*FIELD_W +: FIELD_W]),
            .periph (periph_req[g]),
            .cmp    (cmp_evt[g]),
            .irq    (irq_req[g]),
            .addr   (irq_vec_addr[g*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: tb/test_irq_share_sel.sv
module test_irq_share_sel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  periph_req = '0, cmp_evt = '0, irq_req;
    logic [63:0] irq_vec_addr;
    logic        wdt_kick;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    irq_share_sel i_irq_share_sel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .periph_req(periph_req),
        .cmp_evt(cmp_evt), .irq_req(irq_req), .irq_vec_addr(irq_vec_addr),
        .wdt_kick(wdt_kick)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [3:0] model(logic [7:0] en, logic [7:0] mode,
                                         logic [3:0] p, logic [3:0] c);
        logic [3:0] r;
        for (int n = 0; n < 4; n++)
            r[n] = en[2+n] & ((mode[2*n +: 2] == 2'b10) ? c[n] : p[n]);
        return r;
    endfunction

    task automatic wr(logic sel, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic drive_check(string req, logic [7:0] en, logic [7:0] mode,
                               logic [3:0] p, logic [3:0] c);
        periph_req = p; cmp_evt = c;
        @(negedge clk);
        chk(req, irq_req, model(en, mode, p, c));
    endtask

    task automatic t_reset;
        rd_sel = 0; #0 chk("R1 enable reg", rd_data, 0);
        rd_sel = 1; #1 chk("R1 mode reg", rd_data, 0);
        chk("R1 irq", irq_req, 0);
        chk("R1 wdt", wdt_kick, 0);
    endtask

    task automatic t_addr;
        chk("R2 vec0", irq_vec_addr[15:0],  16'h0053);
        chk("R2 vec1", irq_vec_addr[31:16], 16'h005B);
        chk("R2 vec2", irq_vec_addr[47:32], 16'h0063);
        chk("R2 vec3", irq_vec_addr[63:48], 16'h006B);
    endtask

    task automatic t_regs;
        wr(0, 8'hBF); rd_sel = 0; #1 chk("R3 enable readback", rd_data, 8'hBE);
        wr(1, 8'hA5); rd_sel = 1; #1 chk("R3 mode readback", rd_data, 8'hA5);
    endtask

    task automatic t_enable_map;
        wr(1, 8'h00);
        for (int n = 0; n < 4; n++) begin
            wr(0, 8'(1 << (2+n)));
            drive_check("R4 single enable", 8'(1 << (2+n)), 8'h00, 4'hF, 4'h0);
        end
        wr(0, 8'h00);
        drive_check("R4 all masked", 8'h00, 8'h00, 4'hF, 4'hF);
    endtask

    task automatic t_compare;
        wr(0, 8'h3C); wr(1, 8'hAA);
        drive_check("R5 periph blocked", 8'h3C, 8'hAA, 4'hF, 4'h0);
        drive_check("R5 compare drives", 8'h3C, 8'hAA, 4'h0, 4'hF);
        drive_check("R5 mixed", 8'h3C, 8'hAA, 4'h5, 4'h6);
    endtask

    task automatic t_other_modes;
        logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b11};
        wr(0, 8'h3C);
        foreach (codes[k]) begin
            wr(1, {4{codes[k]}});
            drive_check("R6 periph owns", 8'h3C, {4{codes[k]}}, 4'hF, 4'h0);
            drive_check("R6 cmp ignored", 8'h3C, {4{codes[k]}}, 4'h0, 4'hF);
        end
    endtask

    task automatic t_indep;
        wr(0, 8'h3C); wr(1, 8'h20);
        drive_check("R7 only vec2 taken", 8'h3C, 8'h20, 4'hF, 4'h0);
        chk("R7 literal", irq_req, 4'b1011);
        drive_check("R7 cmp2 only", 8'h3C, 8'h20, 4'h0, 4'hF);
        chk("R7 literal cmp", irq_req, 4'b0100);
    endtask

    task automatic t_comp_mask;
        wr(1, 8'hAA); wr(0, 8'h2C);
        drive_check("R8 compare masked", 8'h2C, 8'hAA, 4'h0, 4'hF);
        chk("R8 literal", irq_req, 4'b1011);
    endtask

    task automatic t_wdt;
        wr(0, 8'h00);
        @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 8'h40;
        #1 chk("R9 no early pulse", wdt_kick, 0);
        @(negedge clk); wr_en = 0;
        chk("R9 pulse high", wdt_kick, 1);
        rd_sel = 0; #1 chk("R9 bit reads 0", rd_data, 8'h00);
        @(negedge clk);
        chk("R9 pulse one cycle", wdt_kick, 0);
    endtask

    task automatic t_latency;
        wr(1, 8'h00); wr(0, 8'h3C);
        periph_req = 0; cmp_evt = 0; @(negedge clk);
        periph_req = 4'h1; #1 chk("R10 before edge", irq_req, 0);
        @(negedge clk); chk("R10 after edge", irq_req, 4'h1);
        periph_req = 4'hF; @(negedge clk);
        wr(1, 8'hAA);
        chk("R10 old mode on write edge", irq_req, 4'hF);
        @(negedge clk); chk("R10 new mode next edge", irq_req, 4'h0);
    endtask

    task automatic t_unused;
        wr(1, 8'h00); wr(0, 8'h82);
        drive_check("R11 no effect", 8'h82, 8'h00, 4'hF, 4'hF);
        rd_sel = 0; #1 chk("R11 readback", rd_data, 8'h82);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_addr(); t_regs(); t_enable_map(); t_compare();
        t_other_modes(); t_indep(); t_comp_mask(); t_wdt(); t_latency(); t_unused();
        summary();
    end
endmodule